// File: doc/BRIEF.md
# Register Rename Map Table

This block sits between decode and dispatch and gives every architectural register write its own physical register. Four architectural registers (A=0, B=1, C=2, D=3) are backed by sixteen physical registers. For each accepted instruction the block does three things. It looks up the current physical register of each source operand. It then takes a fresh physical register from a FIFO free list for the destination and records it as the new mapping. Because every write lands in a new location, write-after-write and write-after-read hazards disappear, and a reader still sees the physical register of the most recent earlier writer.

Decoded instructions arrive on a valid/ready handshake. Each has two optional source slots and one optional destination slot, each with its own enable. The renamed instruction leaves on the next cycle as a single-cycle valid pulse. It carries the physical source numbers, the new destination number and the destination's previous mapping, which the commit stage returns through the free port once the value is dead. When the free list is empty, an instruction that needs a destination is held off until a register comes back.

Top module: `reg_rename_top`

## Requirements
- R1: Out of reset, architectural registers 0..3 map to physical registers 0..3, and a source lookup returns those numbers.
- R2: Out of reset, the free list holds physical 4..15, and successive allocations hand them out in ascending order starting with 4.
- R3: A source operand returns the physical register written by the most recent earlier accepted instruction whose destination is that architectural register.
- R4: Within one instruction, sources read the mapping as it stood before that instruction's destination is reallocated.
- R5: Each destination gets a physical register different from its previous mapping, and the previous mapping is reported on the old-register output.
- R6: The free list is first-in first-out: a register returned on the free port is handed out after all registers already queued, in return order.
- R7: With the free list empty, in_ready_o is low for an instruction with the destination enable set. A register returned in cycle t allows acceptance in cycle t+1.
- R8: An instruction with the destination enable clear is accepted even when the free list is empty, consumes no register, and leaves the map unchanged.
- R9: A disabled source slot reports physical 0 with its enable low. With the destination enable clear, the destination and old-register fields are 0.
- R10: out_valid_o is high in exactly the cycle after each accepted instruction (in_valid_i and in_ready_o high at an edge), and low otherwise.
- R11: A return and an allocation in the same cycle both take effect. With one register free, the returned register is the next one allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decoded instruction present |
| in_ready_o | output | 1 | Instruction accepted at this edge if valid |
| in_src0_en_i | input | 1 | Source 0 is a register (not immediate) |
| in_src0_arch_i | input | 2 | Source 0 architectural register |
| in_src1_en_i | input | 1 | Source 1 is a register (not immediate) |
| in_src1_arch_i | input | 2 | Source 1 architectural register |
| in_dst_en_i | input | 1 | Instruction writes a register |
| in_dst_arch_i | input | 2 | Destination architectural register |
| free_valid_i | input | 1 | Return a physical register to the free list |
| free_phys_i | input | 4 | Physical register being returned |
| out_valid_o | output | 1 | Renamed instruction valid (one cycle) |
| out_src0_en_o | output | 1 | Source 0 enable, passed through |
| out_src0_phys_o | output | 4 | Source 0 physical register |
| out_src1_en_o | output | 1 | Source 1 enable, passed through |
| out_src1_phys_o | output | 4 | Source 1 physical register |
| out_dst_en_o | output | 1 | Destination enable, passed through |
| out_dst_phys_o | output | 4 | Newly allocated physical register |
| out_old_phys_o | output | 4 | Previous mapping of the destination |

## Verification
The state that is hardest to reach from the ports is an empty free list. Random traffic that also returns registers tends to keep it partly full. The bench therefore first drives twelve back-to-back writes with no returns. It then holds a write against the drained list, sends a destination-free instruction through it, and returns one register to release the stall. It also returns a register in the same cycle as the allocation that takes the last free entry. After that, constrained-random traffic frees only registers that have been reported as old mappings, so the pool stays conserved while the list keeps emptying and refilling.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned ARCH_N = 4;
  localparam int unsigned PHYS_N = 16;
  localparam int unsigned AW     = $clog2(ARCH_N);
  localparam int unsigned PW     = $clog2(PHYS_N);

  typedef struct packed {
    logic          src0_en;
    logic [PW-1:0] src0_phys;
    logic          src1_en;
    logic [PW-1:0] src1_phys;
    logic          dst_en;
    logic [PW-1:0] dst_phys;
    logic [PW-1:0] old_phys;
  } renamed_t;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned ARCH_N = 4,
  parameter int unsigned PHYS_N = 16,
  parameter int unsigned RD_N   = 3,
  localparam int unsigned AW = $clog2(ARCH_N),
  localparam int unsigned PW = $clog2(PHYS_N)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [RD_N-1:0][AW-1:0] rd_arch_i,
  output logic [RD_N-1:0][PW-1:0] rd_phys_o,
  input  logic                   we_i,
  input  logic [AW-1:0]          wr_arch_i,
  input  logic [PW-1:0]          wr_phys_i
);
  logic [ARCH_N-1:0][PW-1:0] map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ARCH_N; i++) map_q[i] <= PW'(i);
    end else if (we_i) begin
      map_q[wr_arch_i] <= wr_phys_i;
    end
  end

  // reads see the pre-write mapping
  for (genvar g = 0; g < RD_N; g++) begin : g_rd
    assign rd_phys_o[g] = map_q[rd_arch_i[g]];
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned ARCH_N = 4,
  parameter int unsigned PHYS_N = 16,
  localparam int unsigned PW = $clog2(PHYS_N),
  localparam int unsigned CW = $clog2(PHYS_N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  output logic [PW-1:0] head_o,
  output logic          empty_o,
  input  logic          push_i,
  input  logic [PW-1:0] push_phys_i,
  output logic [CW-1:0] cnt_o
);
  localparam int unsigned INIT_N = PHYS_N - ARCH_N;

  logic [PHYS_N-1:0][PW-1:0] mem_q;
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(PHYS_N - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PHYS_N; i++)
        mem_q[i] <= (i < INIT_N) ? PW'(i + ARCH_N) : '0;
      rd_q  <= '0;
      wr_q  <= PW'(INIT_N % PHYS_N);
      cnt_q <= CW'(INIT_N);
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= push_phys_i;
        wr_q        <= ptr_inc(wr_q);
      end
      if (pop_i) rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/rn_out_stage.sv
module rn_out_stage
  import rn_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  renamed_t data_i,
  output logic     valid_o,
  output renamed_t data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/reg_rename_top.sv
module reg_rename_top
  import rn_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic          in_src0_en_i,
  input  logic [AW-1:0] in_src0_arch_i,
  input  logic          in_src1_en_i,
  input  logic [AW-1:0] in_src1_arch_i,
  input  logic          in_dst_en_i,
  input  logic [AW-1:0] in_dst_arch_i,
  input  logic          free_valid_i,
  input  logic [PW-1:0] free_phys_i,
  output logic          out_valid_o,
  output logic          out_src0_en_o,
  output logic [PW-1:0] out_src0_phys_o,
  output logic          out_src1_en_o,
  output logic [PW-1:0] out_src1_phys_o,
  output logic          out_dst_en_o,
  output logic [PW-1:0] out_dst_phys_o,
  output logic [PW-1:0] out_old_phys_o
);
  localparam int unsigned CW = $clog2(PHYS_N + 1);

  logic [2:0][AW-1:0] rd_arch;
  logic [2:0][PW-1:0] rd_phys;
  logic               fire, alloc, fl_empty;
  logic [PW-1:0]      fl_head;
  logic [CW-1:0]      free_cnt;
  renamed_t           nxt, cur;

  assign in_ready_o = ~fl_empty | ~in_dst_en_i;
  assign fire       = in_valid_i & in_ready_o;
  assign alloc      = fire & in_dst_en_i;

  assign rd_arch[0] = in_src0_arch_i;
  assign rd_arch[1] = in_src1_arch_i;
  assign rd_arch[2] = in_dst_arch_i;

  rn_map_table #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N), .RD_N(3)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_arch_i (rd_arch),
    .rd_phys_o (rd_phys),
    .we_i      (alloc),
    .wr_arch_i (in_dst_arch_i),
    .wr_phys_i (fl_head)
  );

  rn_free_list #(.ARCH_N(ARCH_N), .PHYS_N(PHYS_N)) u_fl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_i       (alloc),
    .head_o      (fl_head),
    .empty_o     (fl_empty),
    .push_i      (free_valid_i),
    .push_phys_i (free_phys_i),
    .cnt_o       (free_cnt)
  );

  always_comb begin
    nxt.src0_en   = in_src0_en_i;
    nxt.src0_phys = in_src0_en_i ? rd_phys[0] : '0;
    nxt.src1_en   = in_src1_en_i;
    nxt.src1_phys = in_src1_en_i ? rd_phys[1] : '0;
    nxt.dst_en    = in_dst_en_i;
    nxt.dst_phys  = in_dst_en_i ? fl_head : '0;
    nxt.old_phys  = in_dst_en_i ? rd_phys[2] : '0;
  end

  rn_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (fire),
    .data_i  (nxt),
    .valid_o (out_valid_o),
    .data_o  (cur)
  );

  assign out_src0_en_o   = cur.src0_en;
  assign out_src0_phys_o = cur.src0_phys;
  assign out_src1_en_o   = cur.src1_en;
  assign out_src1_phys_o = cur.src1_phys;
  assign out_dst_en_o    = cur.dst_en;
  assign out_dst_phys_o  = cur.dst_phys;
  assign out_old_phys_o  = cur.old_phys;
endmodule

// File: rtl/rn_checker.sv
module rn_checker
  import rn_pkg::*;
#(
  localparam int unsigned CW = $clog2(PHYS_N + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          in_dst_en_i,
  input logic          free_valid_i,
  input logic          out_valid_o,
  input logic          out_src0_en_o,
  input logic [PW-1:0] out_src0_phys_o,
  input logic          out_src1_en_o,
  input logic [PW-1:0] out_src1_phys_o,
  input logic          out_dst_en_o,
  input logic [PW-1:0] out_dst_phys_o,
  input logic [PW-1:0] out_old_phys_o,
  input logic [CW-1:0] free_cnt
);
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_valid_i |-> (free_cnt < CW'(PHYS_N)));

  p_cnt_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt <= CW'(PHYS_N - ARCH_N));

  p_stall_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_cnt == '0 && in_dst_en_i) |-> !in_ready_o);

  p_nodst_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_dst_en_i |-> in_ready_o);

  p_out_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  p_out_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> !out_valid_o);

  p_fresh_dst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_dst_en_o) |-> (out_dst_phys_o != out_old_phys_o));

  p_alloc_drains_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_dst_en_i && !free_valid_i) |=>
      (free_cnt == $past(free_cnt) - 1'b1));

  p_src_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_src0_en_o || out_src0_phys_o == '0) &&
                     (out_src1_en_o || out_src1_phys_o == '0)));
endmodule

bind reg_rename_top rn_checker u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .in_valid_i      (in_valid_i),
  .in_ready_o      (in_ready_o),
  .in_dst_en_i     (in_dst_en_i),
  .free_valid_i    (free_valid_i),
  .out_valid_o     (out_valid_o),
  .out_src0_en_o   (out_src0_en_o),
  .out_src0_phys_o (out_src0_phys_o),
  .out_src1_en_o   (out_src1_en_o),
  .out_src1_phys_o (out_src1_phys_o),
  .out_dst_en_o    (out_dst_en_o),
  .out_dst_phys_o  (out_dst_phys_o),
  .out_old_phys_o  (out_old_phys_o),
  .free_cnt        (free_cnt)
);

// File: tb/sim_reg_rename_top.sv
`timescale 1ns/1ps
module sim_reg_rename_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ready;
  logic       s0_en = 1'b0, s1_en = 1'b0, d_en = 1'b0;
  logic [1:0] s0 = '0, s1 = '0, d = '0;
  logic       f_valid = 1'b0;
  logic [3:0] f_phys = '0;
  logic       o_valid, o_s0_en, o_s1_en, o_d_en;
  logic [3:0] o_s0, o_s1, o_d, o_old;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // bench model
  int mdl_map [4];
  int q [16];
  int qh, qt, qc;
  int pend [16];
  int pc;

  always #2 clk = ~clk;

  reg_rename_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_src0_en_i(s0_en), .in_src0_arch_i(s0),
    .in_src1_en_i(s1_en), .in_src1_arch_i(s1),
    .in_dst_en_i(d_en), .in_dst_arch_i(d),
    .free_valid_i(f_valid), .free_phys_i(f_phys),
    .out_valid_o(o_valid),
    .out_src0_en_o(o_s0_en), .out_src0_phys_o(o_s0),
    .out_src1_en_o(o_s1_en), .out_src1_phys_o(o_s1),
    .out_dst_en_o(o_d_en), .out_dst_phys_o(o_d),
    .out_old_phys_o(o_old)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int lookup(input int en, input int a);
    return en ? mdl_map[a] : 0;
  endfunction

  // one cycle: drive at negedge, check ready, check registered outputs after edge
  task automatic step(input int v, input int a0, input int e0, input int a1, input int e1,
                      input int ad, input int de, input int fv, input int fp);
    int ex_rdy, ex_fire, ex_s0, ex_s1, ex_d, ex_old;
    @(negedge clk);
    in_valid = v[0]; s0 = a0[1:0]; s0_en = e0[0]; s1 = a1[1:0]; s1_en = e1[0];
    d = ad[1:0]; d_en = de[0]; f_valid = fv[0]; f_phys = fp[3:0];
    #0.5;
    ex_rdy  = (qc != 0 || de == 0) ? 1 : 0;
    chk(in_ready == ex_rdy[0], "R7 ready", int'(in_ready), ex_rdy);
    ex_fire = v & ex_rdy;
    ex_s0   = lookup(e0, a0);
    ex_s1   = lookup(e1, a1);
    ex_d    = de ? q[qh] : 0;
    ex_old  = de ? mdl_map[ad] : 0;
    if (ex_fire != 0 && de != 0) begin
      mdl_map[ad] = ex_d;
      qh = (qh + 1) % 16;
      qc--;
      pend[pc] = ex_old;
      pc++;
    end
    if (fv != 0) begin
      q[qt] = fp;
      qt = (qt + 1) % 16;
      qc++;
    end
    @(posedge clk);
    #1;
    chk(o_valid == ex_fire[0], "R10 out_valid", int'(o_valid), ex_fire);
    if (ex_fire != 0) begin
      chk(int'(o_s0) == ex_s0 && o_s0_en == e0[0], "R3 src0", int'(o_s0), ex_s0);
      chk(int'(o_s1) == ex_s1 && o_s1_en == e1[0], "R3 src1", int'(o_s1), ex_s1);
      chk(int'(o_d) == ex_d && o_d_en == de[0], "R5 dst", int'(o_d), ex_d);
      chk(int'(o_old) == ex_old, "R5 old", int'(o_old), ex_old);
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic give_back(input int idx, output int fp);
    fp = pend[idx];
    pend[idx] = pend[pc - 1];
    pc--;
  endtask

  initial begin
    int fp;
    void'($urandom(32'h5eed_2024));
    for (int i = 0; i < 4; i++) mdl_map[i] = i;
    for (int i = 0; i < 12; i++) q[i] = i + 4;
    qh = 0; qt = 12; qc = 12; pc = 0;

    repeat (3) @(posedge clk);
    #1;
    chk(o_valid == 1'b0, "R10 reset out_valid", int'(o_valid), 0);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset mapping via lookups without destination
    step(1, 0, 1, 1, 1, 0, 0, 0, 0);
    chk(o_s0 == 4'd0 && o_s1 == 4'd1, "R1 A,B", int'(o_s0) * 16 + int'(o_s1), 1);
    step(1, 2, 1, 3, 1, 0, 0, 0, 0);
    chk(o_s0 == 4'd2 && o_s1 == 4'd3, "R1 C,D", int'(o_s0) * 16 + int'(o_s1), 2 * 16 + 3);
    chk(o_d == 4'd0 && o_old == 4'd0, "R9 no-dst fields zero", int'(o_d), 0);

    // R2, R4: A = A + B, first allocation is 4, sources see old A
    step(1, 0, 1, 1, 1, 0, 1, 0, 0);
    chk(o_d == 4'd4, "R2 first alloc", int'(o_d), 4);
    chk(o_s0 == 4'd0, "R4 src before dst update", int'(o_s0), 0);
    chk(o_old == 4'd0, "R5 old of A", int'(o_old), 0);
    // R9: immediate source
    step(1, 3, 0, 0, 1, 1, 1, 0, 0);
    chk(o_s0 == 4'd0 && !o_s0_en, "R9 disabled src", int'(o_s0), 0);
    chk(o_s1 == 4'd4, "R3 reads latest A", int'(o_s1), 4);
    chk(o_d == 4'd5, "R2 second alloc", int'(o_d), 5);

    // drain: 10 more writes to C
    for (int i = 0; i < 10; i++) step(1, 2, 1, 0, 0, 2, 1, 0, 0);
    chk(o_d == 4'd15, "R2 last initial reg", int'(o_d), 15);
    // R7: stall on empty list
    step(1, 0, 1, 0, 0, 3, 1, 0, 0);
    chk(in_ready == 1'b0 && o_valid == 1'b0, "R7 stall empty", int'(in_ready), 0);
    // R8: no-dst passes while empty
    step(1, 2, 1, 0, 0, 0, 0, 0, 0);
    chk(o_valid == 1'b1 && o_s0 == 4'd15, "R8 no-dst when empty", int'(o_s0), 15);
    chk(qc == 0, "R8 no reg consumed", qc, 0);
    // return one while stalled, then it is used
    give_back(0, fp);
    step(1, 0, 0, 0, 0, 3, 1, 1, fp);
    chk(o_valid == 1'b0, "R7 stall in return cycle", int'(o_valid), 0);
    step(1, 0, 0, 0, 0, 3, 1, 0, 0);
    chk(int'(o_d) == fp, "R6 returned reg allocated", int'(o_d), fp);
    // R11: list has 1, allocate and return in same cycle
    give_back(0, fp);
    step(0, 0, 0, 0, 0, 0, 0, 1, fp);
    give_back(0, fp);
    step(1, 0, 0, 0, 0, 1, 1, 1, fp);
    step(1, 0, 0, 0, 0, 1, 1, 0, 0);
    chk(int'(o_d) == fp, "R11 simultaneous return", int'(o_d), fp);
    idle();

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int fv, fpr;
      fv = 0; fpr = 0;
      if (pc > 0 && ($urandom % 3) == 0) begin
        fv = 1;
        give_back(int'($urandom % pc), fpr);
      end
      step(($urandom % 4) != 0, $urandom % 4, ($urandom % 4) != 0,
           $urandom % 4, ($urandom % 3) != 0, $urandom % 4,
           ($urandom % 5) != 0, fv, fpr);
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule